// File: doc/BRIEF.md
# Strap-Latched Configuration Register Bank

This block holds the configuration state of a multi-output clock generator. It has eight byte-wide registers behind a plain byte-addressed port, and the serial bus front end that drives this port lies outside it. While reset is held, and on the first clock edge after reset is released, it captures six board strap levels: a 4-bit frequency code, a platform-type strap and a graphics-bus speed strap. It then holds them unchanged until the next reset.

From the registers and the captured straps it produces the controls that the clock gating and divider logic needs. These are the effective 4-bit frequency code, the effective graphics speed select, a spread-spectrum enable, a global output tristate and one enable for each clock output. Software can take the frequency code from the captured straps or from a register field, and it can invert the graphics speed strap. The captured straps and the live levels of the three clock-stop pins can be read back at fixed bit positions.

Top module: `strap_cfg_regs`

## Requirements
- R1: After reset the registers read as follows. Byte 0 reads 0x00. Bytes 1, 2, 3 and 5 read 0xFF. Byte 6 reads 0x29. Byte 7 bit 0 reads 0. Byte 4 bits 3:0 read 0xF. Every per-output enable is 1, `io_clk_24m` is 1, and `spread_en` and `outputs_hiz` are 0.
- R2: The strap inputs are captured on every rising edge while `rst_n` is low and on the first rising edge after release. They are then held: later strap pin changes affect no output and no read data until the next reset.
- R3: Byte 4 bits 7:4 read the captured `freq_strap[3:0]` inverted, with bit 7 holding the inverse of `freq_strap[3]`. Writes to these bits have no effect.
- R4: `freq_code` equals byte 0 bits 7:4 when byte 0 bit 3 is 1. When byte 0 bit 3 is 0, it equals the captured `freq_strap` levels.
- R5: `spread_en` follows byte 0 bit 1 and `outputs_hiz` follows byte 0 bit 0. Byte 0 bit 2 is reserved and always reads 0.
- R6: Byte 7 bits 5 down to 1 read, in this order, the captured `gfx_strap`, the captured `platform_strap`, and the live `cpu_halt_n`, `pci_halt_n` and `mem_halt_n` levels. Byte 7 bits 7:6 read 0 and cannot be written.
- R7: `gfx_sel_eff` equals the captured `gfx_strap` XOR byte 7 bit 0.
- R8: `io_clk_24m` follows byte 5 bit 7, where 1 selects 24 MHz and 0 selects 48 MHz.
- R9: Each enable output follows its register field:
  - `pci_en` = byte 1 bits 5:0.
  - `mem_en` = {byte 2 bits 4:0, byte 3}.
  - `fixed_en` = byte 2 bits 6:5.
  - `ref_en` = byte 4 bits 3:2.
  - `gfx_en` = byte 4 bits 1:0.
  - `cpu_en` = byte 5 bits 3:1.
- R10: Byte 6 always reads 0x29. The reserved bits keep reading their reset value of 1 through any write: byte 1 bits 7:6, byte 2 bit 7, and byte 5 bits 6:4 and bit 0.
- R11: Addresses 8 to 15 read 0x00, and a write to them changes no register or output.
- R12: A write is taken on the rising edge where `wr_en` is 1. `rdata` is combinational from `addr`, so it shows the new value in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_strap | input | 4 | Frequency-code strap pins |
| platform_strap | input | 1 | Platform-type strap pin |
| gfx_strap | input | 1 | Graphics-bus speed strap pin |
| cpu_halt_n | input | 1 | Live processor clock-stop pin, active low |
| pci_halt_n | input | 1 | Live peripheral-bus clock-stop pin, active low |
| mem_halt_n | input | 1 | Live memory clock-stop pin, active low |
| addr | input | 4 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| freq_code | output | 4 | Effective frequency code |
| gfx_sel_eff | output | 1 | Effective graphics speed select |
| spread_en | output | 1 | Spread-spectrum enable |
| outputs_hiz | output | 1 | Tristate all clock outputs |
| io_clk_24m | output | 1 | 1 selects 24 MHz on the I/O clock, 0 selects 48 MHz |
| pci_en | output | 6 | Peripheral-bus clock enables |
| mem_en | output | 13 | Memory clock enables |
| fixed_en | output | 2 | Fixed 48 MHz and I/O clock enables |
| ref_en | output | 2 | Reference clock enables |
| gfx_en | output | 2 | Graphics clock enables |
| cpu_en | output | 3 | Processor clock enables |

## Verification
A wrong capture of the straps, or a capture that slips after reset, shows on `freq_code`, on `gfx_sel_eff` and in read bytes 4 and 7 within one cycle of the pins changing. A write that lands in the wrong byte, a write mask with a bad bit, or a lost reserved bit shows on the next read of that byte and on the enable outputs. Both appear in the cycle after the write edge. The bench therefore reads every address and compares every output after each directed step. It also compares every output after each random write, together with a random read.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_REGS   = 8;
  localparam int unsigned REG_IDX_W  = $clog2(NUM_REGS);
  localparam int unsigned FREQ_W     = 4;
  localparam int unsigned N_PCI      = 6;
  localparam int unsigned N_MEM      = 13;
  localparam int unsigned N_FIXED    = 2;
  localparam int unsigned N_REF      = 2;
  localparam int unsigned N_GFX      = 2;
  localparam int unsigned N_CPU      = 3;

  // byte indices whose read value is partly overlaid
  localparam int unsigned STRAP_RB_IDX  = 4;
  localparam int unsigned STATUS_RB_IDX = 7;

  localparam logic [BYTE_W-1:0] FIXED_PATTERN = 8'h29;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic [FREQ_W-1:0] freq_inv;   // inverted pin levels
    logic              gfx;
    logic              plat;
  } strap_t;

  // bits software may change, per byte
  function automatic byte_t wr_mask(input int unsigned idx);
    byte_t m;
    case (idx)
      0:       m = 8'hFB;
      1:       m = 8'h3F;
      2:       m = 8'h7F;
      3:       m = 8'hFF;
      4:       m = 8'h0F;
      5:       m = 8'h8E;
      7:       m = 8'h01;
      default: m = 8'h00;
    endcase
    return m;
  endfunction

  // value after reset, reserved bits included
  function automatic byte_t rst_value(input int unsigned idx);
    byte_t v;
    case (idx)
      0:       v = 8'h00;
      4:       v = 8'h0F;
      6:       v = FIXED_PATTERN;
      7:       v = 8'h00;
      default: v = 8'hFF;
    endcase
    return v;
  endfunction

  function automatic byte_t merge_write(input byte_t cur, input byte_t wd, input byte_t m);
    return (cur & ~m) | (wd & m);
  endfunction

  function automatic logic [FREQ_W-1:0] pick_freq(input logic sw_src,
                                                  input logic [FREQ_W-1:0] sw_code,
                                                  input logic [FREQ_W-1:0] inv_latched);
    return sw_src ? sw_code : ~inv_latched;
  endfunction

  function automatic logic apply_toggle(input logic strap, input logic tog);
    return strap ^ tog;
  endfunction

endpackage

// File: rtl/cfg_strap_capture.sv
module cfg_strap_capture
  import cfgbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq_pins,
  input  logic              plat_pin,
  input  logic              gfx_pin,
  output strap_t            straps,
  output logic              locked
);

  strap_t cap_q;
  logic   locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else        locked_q <= 1'b1;
  end

  // follows the pins until the first edge after reset release
  always_ff @(posedge clk) begin
    if (!locked_q) begin
      cap_q.freq_inv <= ~freq_pins;
      cap_q.gfx      <= gfx_pin;
      cap_q.plat     <= plat_pin;
    end
  end

  assign straps = cap_q;
  assign locked = locked_q;

endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  output logic                 in_range,
  output logic [REG_IDX_W-1:0] idx,
  output logic [NUM_REGS-1:0]  wr_hit
);

  localparam int unsigned CMP_W = ADDR_W + 1;

  assign in_range = ({1'b0, addr} < CMP_W'(NUM_REGS));
  assign idx      = addr[REG_IDX_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign wr_hit[i] = wr_en & in_range & (idx == REG_IDX_W'(i));
  end

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import cfgbank_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              wr_hit,
  input  logic [BYTE_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
    localparam byte_t MASK = wr_mask(i);
    localparam byte_t RSTV = rst_value(i);
    byte_t q;

    if (MASK == 8'h00) begin : g_const
      assign q = RSTV;
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= RSTV;
        else if (wr_hit[i]) q <= merge_write(q, wdata, MASK);
      end
    end

    assign regs_q[i] = q;
  end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfgbank_pkg::*;
(
  input  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q,
  input  strap_t                          straps,
  input  logic                            cpu_halt_n,
  input  logic                            pci_halt_n,
  input  logic                            mem_halt_n,
  input  logic                            in_range,
  input  logic [REG_IDX_W-1:0]            idx,
  output logic [BYTE_W-1:0]               rdata
);

  always_comb begin
    rdata = '0;
    if (in_range) begin
      rdata = regs_q[idx];
      if (idx == REG_IDX_W'(STRAP_RB_IDX))
        rdata[7:4] = straps.freq_inv;
      if (idx == REG_IDX_W'(STATUS_RB_IDX))
        rdata[5:1] = {straps.gfx, straps.plat, cpu_halt_n, pci_halt_n, mem_halt_n};
    end
  end

endmodule

// File: rtl/strap_cfg_regs.sv
module strap_cfg_regs
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FREQ_W-1:0]  freq_strap,
  input  logic               platform_strap,
  input  logic               gfx_strap,
  input  logic               cpu_halt_n,
  input  logic               pci_halt_n,
  input  logic               mem_halt_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  rdata,
  output logic [FREQ_W-1:0]  freq_code,
  output logic               gfx_sel_eff,
  output logic               spread_en,
  output logic               outputs_hiz,
  output logic               io_clk_24m,
  output logic [N_PCI-1:0]   pci_en,
  output logic [N_MEM-1:0]   mem_en,
  output logic [N_FIXED-1:0] fixed_en,
  output logic [N_REF-1:0]   ref_en,
  output logic [N_GFX-1:0]   gfx_en,
  output logic [N_CPU-1:0]   cpu_en
);

  localparam int unsigned SNAP_W = FREQ_W + 4 + N_PCI + N_MEM + N_FIXED + N_REF + N_GFX + N_CPU;

  strap_t                          straps;
  logic                            strap_locked;
  logic                            in_range;
  logic [REG_IDX_W-1:0]            idx;
  logic [NUM_REGS-1:0]             wr_hit;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;

  // named internal events for the checker
  logic              src_sel;
  logic [FREQ_W-1:0] sw_code;
  logic              gfx_toggle;
  logic [SNAP_W-1:0] ctrl_snapshot;

  cfg_strap_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_pins (freq_strap),
    .plat_pin  (platform_strap),
    .gfx_pin   (gfx_strap),
    .straps    (straps),
    .locked    (strap_locked)
  );

  cfg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .in_range (in_range),
    .idx      (idx),
    .wr_hit   (wr_hit)
  );

  cfg_reg_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wdata  (wdata),
    .regs_q (regs_q)
  );

  cfg_read_mux u_rmux (
    .regs_q     (regs_q),
    .straps     (straps),
    .cpu_halt_n (cpu_halt_n),
    .pci_halt_n (pci_halt_n),
    .mem_halt_n (mem_halt_n),
    .in_range   (in_range),
    .idx        (idx),
    .rdata      (rdata)
  );

  assign src_sel    = regs_q[0][3];
  assign sw_code    = regs_q[0][7:4];
  assign gfx_toggle = regs_q[STATUS_RB_IDX][0];

  assign freq_code   = pick_freq(src_sel, sw_code, straps.freq_inv);
  assign gfx_sel_eff = apply_toggle(straps.gfx, gfx_toggle);
  assign spread_en   = regs_q[0][1];
  assign outputs_hiz = regs_q[0][0];
  assign io_clk_24m  = regs_q[5][7];

  assign pci_en   = regs_q[1][N_PCI-1:0];
  assign mem_en   = {regs_q[2][4:0], regs_q[3]};
  assign fixed_en = regs_q[2][6:5];
  assign ref_en   = regs_q[STRAP_RB_IDX][3:2];
  assign gfx_en   = regs_q[STRAP_RB_IDX][1:0];
  assign cpu_en   = regs_q[5][3:1];

  assign ctrl_snapshot = {freq_code, gfx_sel_eff, spread_en, outputs_hiz, io_clk_24m,
                          pci_en, mem_en, fixed_en, ref_en, gfx_en, cpu_en};

endmodule

// File: rtl/strap_cfg_regs_chk.sv
module strap_cfg_regs_chk
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SNAP_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [3:0]        freq_code,
  input logic              gfx_sel_eff,
  input logic              spread_en,
  input logic [7:0]        mem_lo,
  input logic              cpu_halt_n,
  input logic              pci_halt_n,
  input logic              mem_halt_n,
  input logic              strap_locked,
  input logic [5:0]        straps_flat,
  input logic              src_sel,
  input logic              gfx_toggle,
  input logic [SNAP_W-1:0] ctrl_snapshot
);

  logic oor;
  assign oor = (int'(addr) >= int'(NUM_REGS));

  // R2: once locked, the captured straps never move
  a_r2_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strap_locked |=> $stable(straps_flat));

  // R4: with the strap source chosen and no write to byte 0, the code holds
  a_r4_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_locked && !src_sel && !(wr_en && addr == ADDR_W'(0))) |=> $stable(freq_code));

  // R5: spread enable lands one edge after a byte 0 write
  a_r5_spread_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0)) |=> (spread_en == $past(wdata[1])));

  // R6: live stop pins appear in byte 7
  a_r6_stop_live: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(7)) |-> (rdata[3:1] == {cpu_halt_n, pci_halt_n, mem_halt_n}));

  // R7: flipping the toggle flips the effective select
  a_r7_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_locked && wr_en && addr == ADDR_W'(7) && (wdata[0] != gfx_toggle))
      |=> (gfx_sel_eff != $past(gfx_sel_eff)));

  // R9: memory enables follow a byte 3 write
  a_r9_mem_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(3)) |=> (mem_lo == $past(wdata)));

  // R10: fixed byte
  a_r10_fixed_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(6)) |-> (rdata == FIXED_PATTERN));

  // R11: out-of-range reads and writes
  a_r11_oor_read: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> (rdata == 8'h00));

  a_r11_oor_write: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_locked && wr_en && oor) |=> $stable(ctrl_snapshot));

endmodule

bind strap_cfg_regs strap_cfg_regs_chk #(.ADDR_W(ADDR_W), .SNAP_W(SNAP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr          (addr),
  .wr_en         (wr_en),
  .wdata         (wdata),
  .rdata         (rdata),
  .freq_code     (freq_code),
  .gfx_sel_eff   (gfx_sel_eff),
  .spread_en     (spread_en),
  .mem_lo        (mem_en[7:0]),
  .cpu_halt_n    (cpu_halt_n),
  .pci_halt_n    (pci_halt_n),
  .mem_halt_n    (mem_halt_n),
  .strap_locked  (strap_locked),
  .straps_flat   (straps),
  .src_sel       (src_sel),
  .gfx_toggle    (gfx_toggle),
  .ctrl_snapshot (ctrl_snapshot)
);

// File: tb/strap_cfg_regs_test.sv
`timescale 1ns/100ps
module strap_cfg_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  freq_strap = 4'h0;
  logic        platform_strap = 1'b0;
  logic        gfx_strap = 1'b0;
  logic        cpu_halt_n = 1'b1;
  logic        pci_halt_n = 1'b1;
  logic        mem_halt_n = 1'b1;
  logic [3:0]  addr = 4'h0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [3:0]  freq_code;
  logic        gfx_sel_eff, spread_en, outputs_hiz, io_clk_24m;
  logic [5:0]  pci_en;
  logic [12:0] mem_en;
  logic [1:0]  fixed_en, ref_en, gfx_en;
  logic [2:0]  cpu_en;

  always #2 clk = ~clk;

  strap_cfg_regs uut (
    .clk(clk), .rst_n(rst_n), .freq_strap(freq_strap), .platform_strap(platform_strap),
    .gfx_strap(gfx_strap), .cpu_halt_n(cpu_halt_n), .pci_halt_n(pci_halt_n),
    .mem_halt_n(mem_halt_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .freq_code(freq_code), .gfx_sel_eff(gfx_sel_eff), .spread_en(spread_en),
    .outputs_hiz(outputs_hiz), .io_clk_24m(io_clk_24m), .pci_en(pci_en), .mem_en(mem_en),
    .fixed_en(fixed_en), .ref_en(ref_en), .gfx_en(gfx_en), .cpu_en(cpu_en)
  );

  int tests = 0;
  int fails = 0;

  // bench model, built from the requirements
  logic [3:0] lat_fs;
  logic       lat_gfx, lat_plat;
  logic [7:0] m0, m1, m2, m3, m5;
  logic [3:0] m4lo;
  logic       m7b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m0 = 8'h00; m1 = 8'hFF; m2 = 8'hFF; m3 = 8'hFF; m5 = 8'hFF;
    m4lo = 4'hF; m7b0 = 1'b0;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    case (a)
      0: m0 = {d[7:3], 1'b0, d[1:0]};
      1: m1 = {2'b11, d[5:0]};
      2: m2 = {1'b1, d[6:0]};
      3: m3 = d;
      4: m4lo = d[3:0];
      5: m5 = {d[7], 3'b111, d[3:1], 1'b1};
      7: m7b0 = d[0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    case (a)
      0: return m0;
      1: return m1;
      2: return m2;
      3: return m3;
      4: return {~lat_fs, m4lo};
      5: return m5;
      6: return 8'h29;
      7: return {2'b00, lat_gfx, lat_plat, cpu_halt_n, pci_halt_n, mem_halt_n, m7b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_for(input int a);
    if (a >= 8) return "R11 oor read";
    case (a)
      0: return "R5 byte0";
      4: return "R3 byte4";
      5: return "R8 byte5";
      6: return "R10 byte6";
      7: return "R6 byte7";
      default: return "R9 enable byte";
    endcase
  endfunction

  task automatic chk_outs(input string ctx);
    chk({"R4 freq_code ", ctx}, freq_code, m0[3] ? m0[7:4] : lat_fs);
    chk({"R7 gfx_sel_eff ", ctx}, gfx_sel_eff, lat_gfx ^ m7b0);
    chk({"R5 spread/hiz ", ctx}, {spread_en, outputs_hiz}, {m0[1], m0[0]});
    chk({"R8 io_clk_24m ", ctx}, io_clk_24m, m5[7]);
    chk({"R9 enables ", ctx}, {pci_en, mem_en, fixed_en, ref_en, gfx_en, cpu_en},
        {m1[5:0], m2[4:0], m3, m2[6:5], m4lo[3:2], m4lo[1:0], m5[3:1]});
  endtask

  task automatic chk_all(input string ctx);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      addr = 4'(a);
      #0.5;
      chk({tag_for(a), " ", ctx}, rdata, exp_rd(a));
    end
    chk_outs(ctx);
  endtask

  task automatic do_reset(input logic [3:0] fs, input logic g, input logic p);
    @(negedge clk);
    rst_n = 1'b0;
    freq_strap = fs; gfx_strap = g; platform_strap = p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lat_fs = fs; lat_gfx = g; lat_plat = p;
    model_reset();
  endtask

  // R12: result visible in the cycle after the write edge
  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    #0.5;
    chk("R12 readback after write", rdata, exp_rd(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));

    // R1, R3, R6: reset values and strap readback
    do_reset(4'b1010, 1'b1, 1'b0);
    chk_all("R1 after reset");

    // R2: strap pins change after lock
    @(negedge clk);
    freq_strap = 4'b0001; gfx_strap = 1'b0; platform_strap = 1'b1;
    chk_all("R2 pins moved");

    // R3: high nibble of byte 4 not writable; low nibble is
    wr(4, 8'h00);
    chk_all("R3 write byte4");

    // R4, R5: software code source, spread, tristate, reserved bit
    wr(0, 8'h6F);
    chk_all("R4 sw source");
    wr(0, 8'h04);
    chk_all("R5 reserved bit2");

    // R6, R7: toggle and upper bits of byte 7
    wr(7, 8'hFF);
    chk_all("R7 toggle set");
    @(negedge clk);
    cpu_halt_n = 1'b0; mem_halt_n = 1'b0;
    chk_all("R6 live stop pins");
    cpu_halt_n = 1'b1; pci_halt_n = 1'b0; mem_halt_n = 1'b1;
    chk_all("R6 live stop pins 2");
    pci_halt_n = 1'b1;

    // R8, R10: byte 5 reserved bits, fixed byte 6
    wr(5, 8'h00);
    wr(6, 8'h00);
    wr(1, 8'h00);
    wr(2, 8'h00);
    chk_all("R10 reserved kept");

    // R11: out-of-range write changes nothing
    wr(9, 8'hFF);
    wr(15, 8'hFF);
    wr(8, 8'h00);
    chk_all("R11 oor write");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int a;
      logic [7:0] d;
      a = int'($urandom_range(15, 0));
      d = 8'($urandom);
      if ($urandom_range(3, 0) == 0) begin
        @(negedge clk);
        cpu_halt_n = 1'($urandom); pci_halt_n = 1'($urandom); mem_halt_n = 1'($urandom);
      end
      wr(a, d);
      chk_outs("R9 random");
      addr = 4'($urandom_range(15, 0));
      #0.5;
      chk("R12 random read", rdata, exp_rd(int'(addr)));
    end

    // R2: second reset captures new straps
    do_reset(4'b0101, 1'b0, 1'b1);
    chk_all("R2 second reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule